// File: doc/BRIEF.md
# Coprocessor Channel Interrupt Router

The router sits between a set of numbered peripheral interrupt channels, a main CPU and an I/O coprocessor. Each channel has a configuration entry with a route bit and a priority level. With the route bit clear, the channel's peripheral request goes to the CPU. With it set, the request is forwarded to the coprocessor on a request vector that has one bit per channel. The coprocessor arbitrates among those requests itself.

The coprocessor can set a per-channel flag with a set command. It does this to tell the CPU that a task is done. A flag can interrupt the CPU only when three things hold: the global coprocessor interrupt enable is on, the channel is routed to the coprocessor, and the channel's priority is nonzero. The peripheral's own interrupt mask plays no part in this path. The CPU handler clears the channel flag by writing 1 to it.

All CPU sources are combined and the highest-numbered active channel is chosen. The registered CPU outputs then carry that channel's vector address (vector base + 2 × channel ID) and its priority.

Top module: `chan_irq_router`

## Requirements
- R1: After reset, all flags are 0 and every channel has route 0 and priority 0. The global enable and the vector base are 0, and cpu_irq_o, cpu_vec_o, cpu_prio_o and cp_req_o are all 0.
- R2: A channel with route 0 and nonzero priority whose peripheral request is high raises cpu_irq_o. cpu_vec_o then equals base + 2 × channel ID (modulo 2^16), and cpu_prio_o equals that channel's priority. For example, base 0xFF00 with channel 0x3D gives 0xFF7A.
- R3: A channel with route 1 forwards its peripheral request on bit <channel ID> of cp_req_o. That request does not raise cpu_irq_o.
- R4: A flag set by the coprocessor on a channel with route 1, when the global enable is 1 and the priority is nonzero, raises cpu_irq_o with vector base + 2 × ID. For example, channel 0x38 with base 0xFF00 gives 0xFF70.
- R5: A flag on a channel with route 0 has no effect on any interrupt output, and neither does any flag while the global enable is 0. The flag itself stays stored.
- R6: When several channels are active, the vector and priority outputs come from the highest channel ID.
- R7: A channel with priority 0 never raises cpu_irq_o.
- R8: A flag-clear write selects a group of 8 flags (group g covers IDs 8g to 8g+7, with data bit i mapping to ID 8g+i). Each 1 bit clears its flag and each 0 bit leaves its flag unchanged.
- R9: If a set command and a clear write hit the same flag in the same cycle, the flag ends up set.
- R10: The CPU outputs are registered. After a change to a flag or to configuration state, they update on the following clock edge, not on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| periph_req_i | input | 128 | Peripheral request per channel |
| cfg_we_i | input | 1 | Write enable for a channel configuration entry |
| cfg_id_i | input | 7 | Channel to configure |
| cfg_route_i | input | 1 | Route bit: 0 sends to the CPU, 1 sends to the coprocessor |
| cfg_prio_i | input | 3 | Priority level (0 masks the channel) |
| gie_we_i | input | 1 | Write enable for the global enable |
| gie_i | input | 1 | Global coprocessor interrupt enable value |
| base_we_i | input | 1 | Write enable for the vector base |
| base_i | input | 16 | Vector base value |
| clr_we_i | input | 1 | Flag clear write strobe |
| clr_grp_i | input | 4 | Flag group selected for clearing |
| clr_data_i | input | 8 | Write-1-to-clear mask for the group |
| cp_set_i | input | 1 | Coprocessor set-flag command |
| cp_set_id_i | input | 7 | Channel whose flag is set |
| flags_o | output | 128 | Flag vector readback |
| cpu_irq_o | output | 1 | CPU interrupt request |
| cpu_vec_o | output | 16 | CPU vector address |
| cpu_prio_o | output | 3 | Priority of the selected request |
| cp_req_o | output | 128 | Requests forwarded to the coprocessor |

## Verification
A wrong route or priority entry shows up as a wrong vector, a wrong priority, or an interrupt that is missing or spurious. This appears on the CPU outputs one edge after the flag or request that exercises the entry. A stuck or lost flag appears on flags_o on the same edge as the set or clear, and on the CPU outputs one edge later. For this reason the bench checks the flag vector and the CPU outputs separately, and checks the one-edge delay between them once explicitly.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  parameter int unsigned N_CH   = 128;
  parameter int unsigned PRIO_W = 3;
  parameter int unsigned VEC_W  = 16;
  parameter int unsigned GRP_SZ = 8;
endpackage

// File: rtl/chan_cfg_store.sv
module chan_cfg_store #(
  parameter int unsigned N_CH   = 128,
  parameter int unsigned PRIO_W = 3,
  localparam int unsigned ID_W  = $clog2(N_CH)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           we_i,
  input  logic [ID_W-1:0]                id_i,
  input  logic                           route_i,
  input  logic [PRIO_W-1:0]              prio_i,
  output logic [N_CH-1:0]                route_o,
  output logic [N_CH-1:0][PRIO_W-1:0]    prio_o,
  output logic [N_CH-1:0]                prio_nz_o
);
  logic [N_CH-1:0]             route_q;
  logic [N_CH-1:0][PRIO_W-1:0] prio_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      route_q <= '0;
      prio_q  <= '0;
    end else if (we_i) begin
      route_q[id_i] <= route_i;
      prio_q[id_i]  <= prio_i;
    end
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_nz
    assign prio_nz_o[c] = |prio_q[c];
  end

  assign route_o = route_q;
  assign prio_o  = prio_q;
endmodule

// File: rtl/chan_flag_bank.sv
module chan_flag_bank #(
  parameter int unsigned N_CH   = 128,
  parameter int unsigned GRP_SZ = 8,
  localparam int unsigned ID_W  = $clog2(N_CH),
  localparam int unsigned N_GRP = N_CH / GRP_SZ,
  localparam int unsigned GRP_W = (N_GRP > 1) ? $clog2(N_GRP) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_i,
  input  logic [ID_W-1:0]   set_id_i,
  input  logic              clr_we_i,
  input  logic [GRP_W-1:0]  clr_grp_i,
  input  logic [GRP_SZ-1:0] clr_data_i,
  output logic [N_CH-1:0]   flags_o
);
  logic [N_CH-1:0] flags_q, set_mask, clr_mask;

  always_comb begin
    set_mask = '0;
    clr_mask = '0;
    if (set_i) set_mask[set_id_i] = 1'b1;
    if (clr_we_i) begin
      for (int b = 0; b < int'(GRP_SZ); b++)
        clr_mask[int'(clr_grp_i) * int'(GRP_SZ) + b] = clr_data_i[b];
    end
  end

  // set beats clear on a collision
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= (flags_q & ~clr_mask) | set_mask;
  end

  assign flags_o = flags_q;

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flags_q[$past(set_id_i)]);  // R9
  AST_FLAGS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_i && !clr_we_i) |=> $stable(flags_q));  // R8
endmodule

// File: rtl/chan_hi_pick.sv
module chan_hi_pick #(
  parameter int unsigned N_CH = 128,
  localparam int unsigned ID_W = $clog2(N_CH)
) (
  input  logic [N_CH-1:0] act_i,
  output logic            found_o,
  output logic [ID_W-1:0] id_o
);
  // ascending scan, last hit is the highest ID
  always_comb begin
    found_o = 1'b0;
    id_o    = '0;
    for (int c = 0; c < int'(N_CH); c++) begin
      if (act_i[c]) begin
        found_o = 1'b1;
        id_o    = ID_W'(c);
      end
    end
  end
endmodule

// File: rtl/chan_irq_router.sv
module chan_irq_router
  import irq_route_pkg::*;
#(
  parameter int unsigned CH_N   = N_CH,
  parameter int unsigned PW     = PRIO_W,
  parameter int unsigned VW     = VEC_W,
  parameter int unsigned GS     = GRP_SZ,
  localparam int unsigned ID_W  = $clog2(CH_N),
  localparam int unsigned N_GRP = CH_N / GS,
  localparam int unsigned GRP_W = (N_GRP > 1) ? $clog2(N_GRP) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [CH_N-1:0] periph_req_i,
  input  logic            cfg_we_i,
  input  logic [ID_W-1:0] cfg_id_i,
  input  logic            cfg_route_i,
  input  logic [PW-1:0]   cfg_prio_i,
  input  logic            gie_we_i,
  input  logic            gie_i,
  input  logic            base_we_i,
  input  logic [VW-1:0]   base_i,
  input  logic            clr_we_i,
  input  logic [GRP_W-1:0] clr_grp_i,
  input  logic [GS-1:0]   clr_data_i,
  input  logic            cp_set_i,
  input  logic [ID_W-1:0] cp_set_id_i,
  output logic [CH_N-1:0] flags_o,
  output logic            cpu_irq_o,
  output logic [VW-1:0]   cpu_vec_o,
  output logic [PW-1:0]   cpu_prio_o,
  output logic [CH_N-1:0] cp_req_o
);
  logic [CH_N-1:0]         route_v, prio_nz, flags, cpu_src, act;
  logic [CH_N-1:0][PW-1:0] prio_v;
  logic                    gie_q, found;
  logic [VW-1:0]           base_q;
  logic [ID_W-1:0]         pick_id;
  logic                    irq_q;
  logic [VW-1:0]           vec_q;
  logic [PW-1:0]           prio_q;

  chan_cfg_store #(.N_CH(CH_N), .PRIO_W(PW)) u_cfg (
    .clk_i, .rst_ni, .we_i(cfg_we_i), .id_i(cfg_id_i), .route_i(cfg_route_i),
    .prio_i(cfg_prio_i), .route_o(route_v), .prio_o(prio_v), .prio_nz_o(prio_nz)
  );

  chan_flag_bank #(.N_CH(CH_N), .GRP_SZ(GS)) u_flags (
    .clk_i, .rst_ni, .set_i(cp_set_i), .set_id_i(cp_set_id_i),
    .clr_we_i, .clr_grp_i, .clr_data_i, .flags_o(flags)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gie_q  <= 1'b0;
      base_q <= '0;
    end else begin
      if (gie_we_i)  gie_q  <= gie_i;
      if (base_we_i) base_q <= base_i;
    end
  end

  // flags only count on channels handed to the coprocessor
  assign cpu_src = (periph_req_i & ~route_v) | (flags & route_v & {CH_N{gie_q}});
  assign act     = cpu_src & prio_nz;

  chan_hi_pick #(.N_CH(CH_N)) u_pick (.act_i(act), .found_o(found), .id_o(pick_id));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q  <= 1'b0;
      vec_q  <= '0;
      prio_q <= '0;
    end else begin
      irq_q  <= found;
      vec_q  <= found ? base_q + {{(VW-ID_W-1){1'b0}}, pick_id, 1'b0} : '0;
      prio_q <= found ? prio_v[pick_id] : '0;
    end
  end

  assign flags_o    = flags;
  assign cpu_irq_o  = irq_q;
  assign cpu_vec_o  = vec_q;
  assign cpu_prio_o = prio_q;
  assign cp_req_o   = periph_req_i & route_v;

  AST_IRQ_NEEDS_PRIO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_irq_o |-> (cpu_prio_o != '0));  // R7
  AST_GIE_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_irq_o && !$past(gie_q)) |-> $past(|(periph_req_i & ~route_v)));  // R5
  AST_CP_NOT_CPU: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_src == '0) |=> !cpu_irq_o);  // R3
endmodule

// File: tb/chan_irq_router_bench.sv
`timescale 1ns/1ps
module chan_irq_router_bench;
  logic         clk = 1'b0, rst_n = 1'b0;
  logic [127:0] periph = '0;
  logic         cfg_we = 0, cfg_route = 0, gie_we = 0, gie = 0, base_we = 0;
  logic [6:0]   cfg_id = '0, set_id = '0;
  logic [2:0]   cfg_prio = '0;
  logic [15:0]  base = '0;
  logic         clr_we = 0, cp_set = 0;
  logic [3:0]   clr_grp = '0;
  logic [7:0]   clr_data = '0;
  logic [127:0] flags, cp_req;
  logic         irq;
  logic [15:0]  vec;
  logic [2:0]   prio;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  chan_irq_router u_chan_irq_router (
    .clk_i(clk), .rst_ni(rst_n), .periph_req_i(periph),
    .cfg_we_i(cfg_we), .cfg_id_i(cfg_id), .cfg_route_i(cfg_route), .cfg_prio_i(cfg_prio),
    .gie_we_i(gie_we), .gie_i(gie), .base_we_i(base_we), .base_i(base),
    .clr_we_i(clr_we), .clr_grp_i(clr_grp), .clr_data_i(clr_data),
    .cp_set_i(cp_set), .cp_set_id_i(set_id), .flags_o(flags),
    .cpu_irq_o(irq), .cpu_vec_o(vec), .cpu_prio_o(prio), .cp_req_o(cp_req)
  );

  task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic settle(); repeat (3) @(negedge clk); endtask

  task automatic chk_cpu(input string tag, input logic ei, input logic [15:0] ev, input logic [2:0] ep);
    check(irq == ei, {tag, " irq"}, 128'(irq), 128'(ei));
    if (ei) begin
      check(vec == ev, {tag, " vec"}, 128'(vec), 128'(ev));
      check(prio == ep, {tag, " prio"}, 128'(prio), 128'(ep));
    end
  endtask

  task automatic wr_cfg(input logic [6:0] id, input logic r, input logic [2:0] p);
    @(negedge clk); cfg_we = 1; cfg_id = id; cfg_route = r; cfg_prio = p;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic wr_gie(input logic v);
    @(negedge clk); gie_we = 1; gie = v; @(negedge clk); gie_we = 0;
  endtask

  task automatic wr_base(input logic [15:0] v);
    @(negedge clk); base_we = 1; base = v; @(negedge clk); base_we = 0;
  endtask

  task automatic set_flag(input logic [6:0] id);
    @(negedge clk); cp_set = 1; set_id = id; @(negedge clk); cp_set = 0;
  endtask

  task automatic clr(input logic [3:0] g, input logic [7:0] d);
    @(negedge clk); clr_we = 1; clr_grp = g; clr_data = d; @(negedge clk); clr_we = 0;
  endtask

  task automatic t_reset();
    check(flags == '0, "R1 flags", flags, '0);
    check(cp_req == '0, "R1 cp_req", cp_req, '0);
    check({irq, vec, prio} == '0, "R1 cpu outs", 128'({irq, vec, prio}), '0);
    periph[5] = 1'b1; settle();  // route 0, prio 0 after reset: nothing
    check(irq == 0 && cp_req == '0, "R1 cfg default", 128'(irq), 0);
    periph = '0;
  endtask

  task automatic t_periph_cpu();
    wr_base(16'hFF00);
    wr_cfg(7'h3D, 0, 3'd5);
    periph[7'h3D] = 1'b1; settle();
    chk_cpu("R2 ch3D", 1, 16'hFF7A, 3'd5);
    check(cp_req == '0, "R2 no cp_req", cp_req, '0);
    periph = '0;
    wr_cfg(7'h7F, 0, 3'd7);
    periph[7'h7F] = 1'b1; settle();
    chk_cpu("R2 ch7F", 1, 16'hFFFE, 3'd7);
    periph = '0; settle();
    check(irq == 0, "R2 released", 128'(irq), 0);
  endtask

  task automatic t_periph_cp();
    wr_cfg(7'h10, 1, 3'd3);
    periph[7'h10] = 1'b1; settle();
    check(cp_req == (128'd1 << 7'h10), "R3 cp_req", cp_req, 128'd1 << 7'h10);
    chk_cpu("R3 no cpu", 0, 0, 0);
    periph = '0;
  endtask

  task automatic t_flag();
    wr_gie(1);
    wr_cfg(7'h38, 1, 3'd2);
    @(negedge clk); cp_set = 1; set_id = 7'h38;
    @(negedge clk); cp_set = 0;
    check(flags[7'h38] == 1, "R10 flag stored", 128'(flags[7'h38]), 1);
    check(irq == 0, "R10 irq not yet", 128'(irq), 0);
    @(negedge clk);
    chk_cpu("R10/R4 ch38", 1, 16'hFF70, 3'd2);
    clr(4'd7, 8'h00); settle();
    check(flags[7'h38] == 1, "R8 zero write keeps", 128'(flags[7'h38]), 1);
    chk_cpu("R8 still pending", 1, 16'hFF70, 3'd2);
    clr(4'd7, 8'h01); settle();
    check(flags == '0, "R8 w1c", flags, '0);
    chk_cpu("R8 irq drops", 0, 0, 0);
  endtask

  task automatic t_route0_flag();
    wr_cfg(7'h20, 0, 3'd4);
    set_flag(7'h20); settle();
    check(flags[7'h20] == 1, "R5 flag kept", 128'(flags[7'h20]), 1);
    chk_cpu("R5 route0 ignored", 0, 0, 0);
    check(cp_req == '0, "R5 cp_req", cp_req, '0);
    wr_cfg(7'h20, 1, 3'd4); settle();
    chk_cpu("R4 reroute", 1, 16'hFF40, 3'd4);
    wr_gie(0); settle();
    chk_cpu("R5 gie off", 0, 0, 0);
    clr(4'd4, 8'h01); wr_gie(1);
  endtask

  task automatic t_highest();
    wr_cfg(7'h05, 1, 3'd1);
    set_flag(7'h38); set_flag(7'h05); settle();
    chk_cpu("R6 highest", 1, 16'hFF70, 3'd2);
    clr(4'd7, 8'h01); settle();
    chk_cpu("R6 next", 1, 16'hFF0A, 3'd1);
    clr(4'd0, 8'h20); settle();
    chk_cpu("R6 none", 0, 0, 0);
  endtask

  task automatic t_prio0();
    wr_cfg(7'h40, 1, 3'd0);
    set_flag(7'h40); settle();
    chk_cpu("R7 masked", 0, 0, 0);
    wr_cfg(7'h40, 1, 3'd6); settle();
    chk_cpu("R7 unmasked", 1, 16'hFF80, 3'd6);
    clr(4'd8, 8'h01); settle();
  endtask

  task automatic t_set_wins();
    @(negedge clk);
    cp_set = 1; set_id = 7'h41; clr_we = 1; clr_grp = 4'd8; clr_data = 8'h02;
    @(negedge clk); cp_set = 0; clr_we = 0;
    check(flags[7'h41] == 1, "R9 set wins", 128'(flags[7'h41]), 1);
    clr(4'd8, 8'h02);
    check(flags == '0, "R9 cleared after", flags, '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_periph_cpu();
    t_periph_cp();
    t_flag();
    t_route0_flag();
    t_highest();
    t_prio0();
    t_set_wins();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule